// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between a clocked request port and an external asynchronous static RAM that holds 64K words of 32 bits. Each of the RAM's four byte lanes has its own active-low chip select. A request carries an address, write data, a four-bit lane mask and a read/write flag. It is accepted with a valid/ready handshake. The block then turns the request into a sequence of RAM strobes. Every phase of that sequence lasts a whole number of clock cycles. These counts are derived at elaboration from the clock period and the RAM's minimum timings, all given in nanoseconds, and each count is rounded up.

A write drives the address and data for one cycle first. It then pulls the selected chip selects and write enable low for the pulse count. Write enable rises first, which ends the write. The address, the data and the lane selects are then held for the hold count. A read pulls the selected chip selects and output enable low for the access count. It then registers the bus and returns the word with a one-cycle valid strobe. Lanes that were not selected come back as zero. After every operation there is one cycle in which all strobes are inactive and the bus is released. Only after that cycle does ready return.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after synchronous reset, until a request is accepted: req_ready is 1, ram_cs_n is 4'b1111, ram_we_n is 1, ram_oe_n is 1, ram_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge until the operation and its idle cycle are over, so a request held valid in the meantime is not taken early.
- R3: In the first cycle after a write is accepted, ram_addr and ram_dq_out carry the request's address and data and ram_dq_oe is 1, while ram_cs_n is 4'b1111 and ram_we_n is 1. The address and data stay unchanged while ram_we_n is 0.
- R4: For the next PULSE cycles, ram_we_n is 0 and ram_cs_n[i] is 0 exactly for the lanes whose mask bit i is 1 (lane i is ram_dq bits 8i+7..8i). PULSE is the largest of 1, ceil(pulse_ns/clk_ns), ceil(setup_ns/clk_ns) and ceil(addr_to_end_ns/clk_ns)-1.
- R5: The write ends with ram_we_n rising while ram_cs_n is unchanged. For the next HOLD = max(1, ceil(hold_ns/clk_ns)) cycles, the lane selects, the address, the data and ram_dq_oe = 1 are all held.
- R6: ram_dq_oe is 1 only during the setup, pulse and hold cycles of a write. It is never 1 while ram_oe_n is 0.
- R7: A read keeps ram_cs_n[i] = ~mask[i], ram_oe_n = 0, ram_we_n = 1 and ram_dq_oe = 0 for ACC = max(1, ceil(access_ns/clk_ns), ceil(oe_access_ns/clk_ns)) cycles, starting in the cycle right after acceptance.
- R8: In the cycle after the last access cycle, rsp_valid is 1 for exactly one cycle. rsp_rdata holds, for each selected lane, the ram_dq_in byte sampled at the end of the last access cycle, and zero for each lane that was not selected.
- R9: Every operation ends with exactly one cycle in which all strobes are inactive and req_ready is 0. req_ready is 1 in the cycle after that.
- R10: With a lane mask of 4'b0000, no chip select goes low. A write then leaves the memory unchanged, and a read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write data |
| req_bmask | input | 4 | Lane mask, bit i selects byte lane i |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| ram_addr | output | 16 | RAM address |
| ram_cs_n | output | 4 | Per-lane chip selects, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 32 | Data driven toward the RAM |
| ram_dq_in | input | 32 | Data returned by the RAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |

## Verification
The bench builds the block with a 10 ns clock and slower timings: a 25 ns pulse, 15 ns data setup, 20 ns address-to-end, 12 ns data hold, 25 ns address access and 15 ns enable access. These give a three-cycle pulse, a two-cycle hold and a three-cycle access, whereas the defaults give a single-cycle pulse and hold. The phase counters therefore have to run past their first value. The hold path in particular is exercised with more than one cycle. The bench's RAM model returns garbage until enough access time has elapsed, and fills unselected lanes with a fixed pattern. As a result, a short access count or a missing lane mask shows up in the returned data.

// File: rtl/sram_ctrl_pkg.sv
// Shared phase type and elaboration-time helpers for the static RAM sequencer.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_RACC,
        PH_GAP
    } phase_e;

    // Integer division rounded toward +infinity.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
// Phase sequencer: walks setup/pulse/hold for writes and access for reads,
// then one idle gap. Assumes counts >= 1 (guaranteed by the top).
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int ACC_CYC   = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase_q,
    output phase_e phase_d,
    output logic   cap_en,
    output logic   ready
);
    localparam int MAXC  = max3(PULSE_CYC, HOLD_CYC, ACC_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LAST   = CNT_W'(ACC_CYC - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next phase and in-phase cycle count.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = '0;
        case (phase_q)
            PH_IDLE:   if (start) phase_d = start_wr ? PH_WSETUP : PH_RACC;
            PH_WSETUP: phase_d = PH_WPULSE;
            PH_WPULSE: if (cnt_q == PULSE_LAST) phase_d = PH_WHOLD;
                       else cnt_d = cnt_q + 1'b1;
            PH_WHOLD:  if (cnt_q == HOLD_LAST) phase_d = PH_GAP;
                       else cnt_d = cnt_q + 1'b1;
            PH_RACC:   if (cnt_q == ACC_LAST) phase_d = PH_GAP;
                       else cnt_d = cnt_q + 1'b1;
            PH_GAP:    phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign ready  = (phase_q == PH_IDLE);
    assign cap_en = (phase_q == PH_RACC) && (cnt_q == ACC_LAST);

    // A started operation always leaves idle on the next edge.
    assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (phase_q != PH_IDLE));

endmodule

// File: rtl/sram_pin_drive.sv
// RAM pin registers: strobes are registered from the next phase so each pin
// changes only at a clock edge, glitch free. Address and data load on accept.
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_d,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [LANES-1:0]  lane_sel,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic [LANES-1:0]  ram_cs_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              ram_dq_oe
);
    logic sel_phase;
    assign sel_phase = (phase_d == PH_WPULSE) || (phase_d == PH_WHOLD) || (phase_d == PH_RACC);

    // Address and write data latch when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr   <= '0;
            ram_dq_out <= '0;
        end else if (load) begin
            ram_addr   <= addr_in;
            ram_dq_out <= wdata_in;
        end
    end

    // Shared strobes follow the upcoming phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_n  <= 1'b1;
            ram_oe_n  <= 1'b1;
            ram_dq_oe <= 1'b0;
        end else begin
            ram_we_n  <= !(phase_d == PH_WPULSE);
            ram_oe_n  <= !(phase_d == PH_RACC);
            ram_dq_oe <= (phase_d == PH_WSETUP) || (phase_d == PH_WPULSE) || (phase_d == PH_WHOLD);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane select: low only for masked-in lanes during an active phase.
        always_ff @(posedge clk) begin
            if (!rst_n) ram_cs_n[g] <= 1'b1;
            else        ram_cs_n[g] <= !(lane_sel[g] && sel_phase);
        end
    end

    assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);
    assert_we_with_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ram_dq_oe);
    assert_oe_excludes_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> ram_we_n);
    assert_we_ends_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> ($stable(ram_cs_n) && ram_dq_oe && $stable(ram_dq_out)));

endmodule

// File: rtl/sram_rd_capture.sv
// Read capture: registers the RAM bus at the end of the access window,
// zeroing unselected lanes, and raises a one-cycle valid.
module sram_rd_capture #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Valid strobe follows the capture enable by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= cap_en;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane byte: sampled when selected, zero otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            else if (cap_en)
                rsp_rdata[g*LANE_W +: LANE_W] <= lane_sel[g] ? ram_dq_in[g*LANE_W +: LANE_W] : '0;
        end
    end

    assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
// Top: request handshake, lane-mask latch and timing-count derivation for a
// byte-selectable asynchronous static RAM. Assumes ram_dq_in is settled by
// the end of the access window; external tri-state uses ram_dq_oe.
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LANE_W     = 8,
    parameter int LANES      = 4,
    parameter int CLK_NS     = 10,
    parameter int T_PULSE_NS = 10,
    parameter int T_SETUP_NS = 8,
    parameter int T_AEND_NS  = 10,
    parameter int T_HOLD_NS  = 2,
    parameter int T_ACC_NS   = 15,
    parameter int T_OEACC_NS = 8,
    localparam int DATA_W    = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_bmask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [LANES-1:0]  ram_cs_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    input  logic [DATA_W-1:0] ram_dq_in,
    output logic              ram_dq_oe
);
    localparam int PULSE_CYC = at_least_one(max3(ceil_div(T_PULSE_NS, CLK_NS),
                                                 ceil_div(T_SETUP_NS, CLK_NS),
                                                 ceil_div(T_AEND_NS, CLK_NS) - 1));
    localparam int HOLD_CYC  = at_least_one(ceil_div(T_HOLD_NS, CLK_NS));
    localparam int ACC_CYC   = at_least_one(max3(ceil_div(T_ACC_NS, CLK_NS),
                                                 ceil_div(T_OEACC_NS, CLK_NS), 1));

    phase_e           phase_q, phase_d;
    logic             accept, cap_en;
    logic [LANES-1:0] mask_q, mask_d;

    assign accept = req_valid && req_ready;
    assign mask_d = accept ? req_bmask : mask_q;

    // Lane mask held for the whole operation, including the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '0;
        else if (accept) mask_q <= req_bmask;
    end

    sram_seq_fsm #(
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .ACC_CYC   (ACC_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_wr (req_write),
        .phase_q  (phase_q),
        .phase_d  (phase_d),
        .cap_en   (cap_en),
        .ready    (req_ready)
    );

    sram_pin_drive #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_d    (phase_d),
        .load       (accept),
        .addr_in    (req_addr),
        .wdata_in   (req_wdata),
        .lane_sel   (mask_d),
        .ram_addr   (ram_addr),
        .ram_dq_out (ram_dq_out),
        .ram_cs_n   (ram_cs_n),
        .ram_we_n   (ram_we_n),
        .ram_oe_n   (ram_oe_n),
        .ram_dq_oe  (ram_dq_oe)
    );

    sram_rd_capture #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .lane_sel  (mask_q),
        .ram_dq_in (ram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // Checker counters: length of the current low run on write and output enable.
    localparam int WCW = $clog2(PULSE_CYC + 2);
    localparam int OCW = $clog2(ACC_CYC + 2);
    logic [WCW-1:0] we_low_cnt;
    logic [OCW-1:0] oe_low_cnt;

    // Count consecutive cycles of active strobes for window checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= ram_we_n ? '0 : we_low_cnt + 1'b1;
            oe_low_cnt <= ram_oe_n ? '0 : oe_low_cnt + 1'b1;
        end
    end

    assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> (we_low_cnt == WCW'(PULSE_CYC)));
    assert_access_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_oe_n) |-> (oe_low_cnt == OCW'(ACC_CYC)));
    assert_addr_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ($stable(ram_addr) && $stable(ram_dq_out)));
    assert_gap_then_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && ram_oe_n && (ram_cs_n == '1)) ##1 req_ready);

endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
    localparam int CLK_NS = 10;
    localparam int PW_NS = 25, SU_NS = 15, AE_NS = 20, HD_NS = 12, AC_NS = 25, OA_NS = 15;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int N_EXP = imax(1, imax(imax(cdiv(PW_NS, CLK_NS), cdiv(SU_NS, CLK_NS)), cdiv(AE_NS, CLK_NS) - 1));
    localparam int H_EXP = imax(1, cdiv(HD_NS, CLK_NS));
    localparam int M_EXP = imax(1, imax(cdiv(AC_NS, CLK_NS), cdiv(OA_NS, CLK_NS)));

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic        req_ready;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_bmask;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [15:0] ram_addr;
    logic [3:0]  ram_cs_n;
    logic        ram_we_n, ram_oe_n, ram_dq_oe;
    logic [31:0] ram_dq_out, ram_dq_in;

    always #5 clk = ~clk;

    sram_lane_ctrl #(
        .CLK_NS (CLK_NS), .T_PULSE_NS (PW_NS), .T_SETUP_NS (SU_NS), .T_AEND_NS (AE_NS),
        .T_HOLD_NS (HD_NS), .T_ACC_NS (AC_NS), .T_OEACC_NS (OA_NS)
    ) u_sram_lane_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
        .req_bmask (req_bmask), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .ram_addr (ram_addr), .ram_cs_n (ram_cs_n), .ram_we_n (ram_we_n),
        .ram_oe_n (ram_oe_n), .ram_dq_out (ram_dq_out), .ram_dq_in (ram_dq_in),
        .ram_dq_oe (ram_dq_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic        ready;
        logic [3:0]  cs_n;
        logic        we_n, oe_n, dq_oe, rsp_valid;
        logic        chk_addr, chk_dout, chk_rdata;
        logic [15:0] addr;
        logic [31:0] dout, rdata;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic [31:0] ref_mem [int unsigned];
    logic [31:0] ram_mem [int unsigned];

    function automatic logic [31:0] ref_get(input int unsigned a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction
    function automatic logic [31:0] ram_get(input int unsigned a);
        return ram_mem.exists(a) ? ram_mem[a] : 32'h0;
    endfunction

    function automatic exp_t idle_e(input string t);
        exp_t e;
        e.ready = 1'b1; e.cs_n = 4'hF; e.we_n = 1'b1; e.oe_n = 1'b1; e.dq_oe = 1'b0;
        e.rsp_valid = 1'b0; e.chk_addr = 1'b0; e.chk_dout = 1'b0; e.chk_rdata = 1'b0;
        e.addr = '0; e.dout = '0; e.rdata = '0; e.tag = t;
        return e;
    endfunction

    // Compare DUT pins with one expected cycle.
    task automatic compare(input exp_t e);
        bit bad;
        n_chk++;
        bad = (req_ready !== e.ready) || (ram_cs_n !== e.cs_n) || (ram_we_n !== e.we_n) ||
              (ram_oe_n !== e.oe_n) || (ram_dq_oe !== e.dq_oe) || (rsp_valid !== e.rsp_valid) ||
              (e.chk_addr && ram_addr !== e.addr) || (e.chk_dout && ram_dq_out !== e.dout) ||
              (e.chk_rdata && rsp_rdata !== e.rdata);
        if (bad) begin
            n_bad++;
            $display("FAIL %s t=%0t actual rdy=%b cs=%b we=%b oe=%b doe=%b rv=%b a=%h d=%h q=%h expected rdy=%b cs=%b we=%b oe=%b doe=%b rv=%b a=%h d=%h q=%h",
                     e.tag, $time, req_ready, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid,
                     ram_addr, ram_dq_out, rsp_rdata, e.ready, e.cs_n, e.we_n, e.oe_n, e.dq_oe,
                     e.rsp_valid, e.addr, e.dout, e.rdata);
        end
    endtask

    task automatic step();
        exp_t e;
        @(negedge clk);
        if (exp_q.size() > 0) e = exp_q.pop_front();
        else e = idle_e("R2");
        compare(e);
    endtask

    // Push the cycle-by-cycle expectation of an accepted operation.
    task automatic push_op(input bit w, input logic [15:0] a, input logic [31:0] d, input logic [3:0] m);
        exp_t e;
        logic [31:0] word, rd;
        if (w) begin
            word = ref_get(a);
            for (int i = 0; i < 4; i++) if (m[i]) word[i*8 +: 8] = d[i*8 +: 8];
            ref_mem[a] = word;
            e = idle_e("R3"); e.ready = 1'b0; e.dq_oe = 1'b1; e.chk_addr = 1'b1; e.chk_dout = 1'b1;
            e.addr = a; e.dout = d;
            exp_q.push_back(e);
            for (int k = 0; k < N_EXP; k++) begin
                e.tag = (m == 4'h0) ? "R10" : "R4"; e.cs_n = ~m; e.we_n = 1'b0;
                exp_q.push_back(e);
            end
            for (int k = 0; k < H_EXP; k++) begin
                e.tag = "R5"; e.we_n = 1'b1;
                exp_q.push_back(e);
            end
            e = idle_e("R9"); e.ready = 1'b0;
            exp_q.push_back(e);
        end else begin
            rd = ref_get(a);
            for (int i = 0; i < 4; i++) if (!m[i]) rd[i*8 +: 8] = 8'h00;
            e = idle_e((m == 4'h0) ? "R10" : "R7"); e.ready = 1'b0; e.cs_n = ~m; e.oe_n = 1'b0;
            e.chk_addr = 1'b1; e.addr = a;
            for (int k = 0; k < M_EXP; k++) exp_q.push_back(e);
            e = idle_e("R8"); e.ready = 1'b0; e.rsp_valid = 1'b1; e.chk_rdata = 1'b1; e.rdata = rd;
            exp_q.push_back(e);
        end
    endtask

    // Present a request and hold it until the design takes it (R2).
    task automatic do_op(input bit w, input logic [15:0] a, input logic [31:0] d, input logic [3:0] m);
        bit acc;
        req_write = w; req_addr = a; req_wdata = d; req_bmask = m; req_valid = 1'b1;
        forever begin
            acc = req_ready;
            if (acc) push_op(w, a, d, m);
            step();
            if (acc) break;
        end
        req_valid = 1'b0;
        req_wdata = 32'hFFFF_FFFF;
    endtask

    // RAM model: samples pins mid-cycle, checks timing, stores writes, drives reads.
    int          rd_cyc;
    logic [15:0] rd_addr_q;
    int          wr_cyc [4];
    logic [15:0] wr_addr [4];
    logic [7:0]  wr_byte [4];
    bit          hold_act;
    int          hold_cyc;
    logic [15:0] h_addr;
    logic [31:0] h_data;

    always @(negedge clk) begin
        logic [31:0] word;
        bit rd_act;
        if (!rst_n) begin
            rd_cyc = 0; hold_act = 0; hold_cyc = 0; ram_dq_in = 32'hDEAD_BEEF;
            for (int i = 0; i < 4; i++) wr_cyc[i] = 0;
        end else begin
            if (ram_dq_oe && !ram_oe_n && ram_cs_n != 4'hF) begin
                n_chk++; n_bad++;
                $display("FAIL R6 bus fight actual oe_n=%b dq_oe=%b expected dq_oe=0", ram_oe_n, ram_dq_oe);
            end
            if (hold_act) begin
                if (ram_dq_oe && ram_addr == h_addr && ram_dq_out == h_data) hold_cyc++;
                else begin
                    hold_act = 0; n_chk++;
                    if (hold_cyc * CLK_NS < HD_NS) begin
                        n_bad++;
                        $display("FAIL R5 data hold actual %0d ns expected >= %0d ns", hold_cyc * CLK_NS, HD_NS);
                    end
                end
            end
            for (int i = 0; i < 4; i++) begin
                if (!ram_cs_n[i] && !ram_we_n) begin
                    if (wr_cyc[i] == 0) begin
                        wr_addr[i] = ram_addr; wr_byte[i] = ram_dq_out[i*8 +: 8];
                    end else if (ram_addr != wr_addr[i] || ram_dq_out[i*8 +: 8] != wr_byte[i] || !ram_dq_oe) begin
                        n_chk++; n_bad++;
                        $display("FAIL R3 lane %0d changed in write actual a=%h b=%h expected a=%h b=%h",
                                 i, ram_addr, ram_dq_out[i*8 +: 8], wr_addr[i], wr_byte[i]);
                    end
                    wr_cyc[i]++;
                end else if (wr_cyc[i] > 0) begin
                    n_chk++;
                    if (wr_cyc[i] * CLK_NS < PW_NS || wr_cyc[i] * CLK_NS < SU_NS) begin
                        n_bad++;
                        $display("FAIL R4 lane %0d pulse actual %0d ns expected >= %0d ns", i, wr_cyc[i] * CLK_NS, PW_NS);
                    end
                    word = ram_get(wr_addr[i]);
                    word[i*8 +: 8] = wr_byte[i];
                    ram_mem[wr_addr[i]] = word;
                    wr_cyc[i] = 0;
                    hold_act = 1; hold_cyc = 1; h_addr = ram_addr; h_data = ram_dq_out;
                end
            end
            rd_act = (ram_cs_n != 4'hF) && !ram_oe_n && ram_we_n;
            if (rd_act && rd_cyc > 0 && ram_addr == rd_addr_q) rd_cyc++;
            else if (rd_act) rd_cyc = 1;
            else rd_cyc = 0;
            rd_addr_q = ram_addr;
            word = ram_get(ram_addr);
            for (int i = 0; i < 4; i++) begin
                if (!rd_act || ram_cs_n[i]) ram_dq_in[i*8 +: 8] = 8'hA5;
                else if (rd_cyc * CLK_NS < AC_NS || rd_cyc * CLK_NS < OA_NS) ram_dq_in[i*8 +: 8] = 8'hE7;
                else ram_dq_in[i*8 +: 8] = word[i*8 +: 8];
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; req_bmask = '0;
        repeat (3) @(negedge clk);
        compare(idle_e("R1"));
        rst_n = 1'b1;
        step();
        compare(idle_e("R1"));
        // R2: idle cycles with no request leave everything quiet
        repeat (3) step();
        // R3 R4 R5 full write, then R7 R8 read back
        do_op(1'b1, 16'h0001, 32'h1122_3344, 4'hF);
        do_op(1'b0, 16'h0001, 32'h0, 4'hF);
        // partial write lanes 0 and 2
        do_op(1'b1, 16'h0001, 32'hAABB_CCDD, 4'b0101);
        do_op(1'b0, 16'h0001, 32'h0, 4'hF);
        // R8: read of lanes 1 and 3 only, others zero
        do_op(1'b0, 16'h0001, 32'h0, 4'b1010);
        // top address, single lane
        do_op(1'b1, 16'hFFFF, 32'h7766_5544, 4'b1000);
        do_op(1'b0, 16'hFFFF, 32'h0, 4'hF);
        // R10: empty mask write and read
        do_op(1'b1, 16'h0001, 32'h0000_0000, 4'h0);
        do_op(1'b0, 16'h0001, 32'h0, 4'h0);
        do_op(1'b0, 16'h0001, 32'h0, 4'hF);
        // R9: back-to-back requests held valid while busy
        lfsr = 16'hACE1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_op(lfsr[0], {13'h0, lfsr[3:1]}, {lfsr, ~lfsr}, lfsr[7:4]);
        end
        for (int k = 0; k < 8; k++) do_op(1'b0, 16'(k), 32'h0, 4'hF);
        repeat (4) step();
        finish_run();
    end

endmodule